// File: doc/BRIEF.md
# Byte Exchange Serial Port with Fault Flags

This block is an 8-bit synchronous serial port that sends and receives a byte at the same time. It can act as the clock-driving master or as a slave clocked from outside. In master mode a simple divider paces SCK. On each rising SCK edge the block samples the incoming line, and on each falling edge it shifts. After eight bits, the byte sent by the master and the byte held by the slave have traded places. Shifting is MSB first.

Software uses a small register window with three registers.

| Address | Register | Read | Write |
|---------|----------|------|-------|
| 0 | Control | Control bits | Control bits |
| 1 | Status | Flag bits | — |
| 2 | Data | Receive holding register | Shifter |

A data write loads the shifter directly. A data read returns the receive holding register, which updates only when a transfer completes. Three sticky flags report events:

- Transfer complete.
- Write collision.
- Mode fault.

Each flag can be cleared only by a two-step access sequence. A mode fault is a master seeing its slave-select input pulled low. When it happens, the block drops master mode at once and releases the lines it drives.

Top module: `spi_fault_ctrl`

## Requirements
- R1: After reset, control (address 0), status (address 1) and the data read (address 2) are all 0x00, and sck_oe, mosi_oe and miso_oe are low.
- R2: A data write in master mode (control 0x03: bit0 enable, bit1 master) while idle starts a transfer. Transfer complete (status bit0) sets exactly 16*DIV_HALF clock cycles after the write edge, and not one cycle earlier.
- R3: A data read returns the byte from the last completed transfer. While a transfer is running, it does not return the partial shifter contents.
- R4: A data write during a transfer sets write collision (status bit1). The written byte is discarded, and the transfer finishes with its original byte.
- R5: Write collision clears only when a status read sees it set and a later read or write of the data register follows. A data access with no such status read leaves it set.
- R6: Transfer complete clears by the same sequence, a status read with the flag set followed by a data access. Without that status read it stays set.
- R7: In master mode with control bit2 at 0, a low level on ss_n_i sets mode fault (status bit2) within four clock cycles. The same event clears the master bit, drops sck_oe and mosi_oe, and aborts a running transfer without setting transfer complete.
- R8: With control bit2 at 1 (slave-select pin used as an output), a low ss_n_i never sets mode fault and leaves master mode on.
- R9: Mode fault clears only when a status read sees it set and a later control write follows. Data accesses and control writes with no prior status read leave it set.
- R10: In slave mode (control 0x01), the block shifts on an external SCK while ss_n_i is low, exchanging its loaded byte with the master's byte MSB first. miso_oe is high only while ss_n_i is low.
- R11: A data write in the very clock cycle in which the eighth bit shifts counts as a collision. Both transfer complete and write collision are set, and the received byte is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the flag-clear sequences) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sck_i | input | 1 | Serial clock from an external master (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode, idle low |
| sck_oe | output | 1 | Drive enable for sck_o |
| mosi_i | input | 1 | Serial data from the master (slave mode) |
| mosi_o | output | 1 | Serial data to the slave (master mode) |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Serial data from the slave (master mode) |
| miso_o | output | 1 | Serial data to the master (slave mode) |
| miso_oe | output | 1 | Drive enable for miso_o |
| ss_n_i | input | 1 | Slave-select input, active low |

## Verification
Two events can land on the same clock edge:

- The shift engine finishing its eighth bit.
- A bus write to the data register.

The bench counts cycles from the start write and places a second data write exactly on the completion edge. It then judges that both transfer complete and write collision are set, and that the received byte and the byte the partner saw are the original ones. A similar overlap arises when a mode fault strikes mid-transfer. The bench provokes it by pulling the slave-select input low partway through, and judges that the transfer ends without a completion flag.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // control bits: [0] enable, [1] master, [2] slave-select pin is an output
    typedef struct packed {
        logic ss_out;
        logic mstr;
        logic en;
    } ctrl_t;

    // status bits: [0] transfer complete, [1] write collision, [2] mode fault
    typedef struct packed {
        logic modf;
        logic wcol;
        logic done;
    } flags_t;

endpackage

// File: rtl/spi_clk_tick.sv
module spi_clk_tick #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         master,
    input  logic         slave_sel,
    input  logic         abort,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         miso_i,
    input  logic         sck_s,
    input  logic         mosi_s,
    output logic         busy,
    output logic         xfer_end,
    output logic         sck,
    output logic         tx_bit,
    output logic [W-1:0] rx_byte
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  shift;
        logic [W-1:0]  rxb;
        logic [CW-1:0] cnt;
        logic          sbit;
        logic          sck;
        logic          busy;
        logic          sck_prev;
    } eng_t;

    eng_t st_d, st_q;
    logic [W-1:0] shifted;
    logic rise, fall;

    always_comb begin
        st_d     = st_q;
        xfer_end = 1'b0;
        shifted  = {st_q.shift[W-2:0], st_q.sbit};
        rise     = sck_s && !st_q.sck_prev;
        fall     = !sck_s && st_q.sck_prev;
        st_d.sck_prev = sck_s;

        if (abort) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
            st_d.sck  = 1'b0;
        end else if (master) begin
            if (load) begin
                st_d.shift = load_data;
                st_d.busy  = 1'b1;
                st_d.cnt   = '0;
                st_d.sck   = 1'b0;
            end else if (st_q.busy && tick) begin
                if (!st_q.sck) begin
                    st_d.sck  = 1'b1;
                    st_d.sbit = miso_i;
                end else begin
                    st_d.sck   = 1'b0;
                    st_d.shift = shifted;
                    st_d.cnt   = st_q.cnt + 1'b1;
                    if (st_q.cnt == LAST) begin
                        st_d.busy = 1'b0;
                        st_d.cnt  = '0;
                        st_d.rxb  = shifted;
                        xfer_end  = 1'b1;
                    end
                end
            end
        end else if (slave_sel) begin
            st_d.sck = 1'b0;
            if (load) st_d.shift = load_data;
            if (rise) begin
                st_d.sbit = mosi_s;
                st_d.busy = 1'b1;
            end else if (fall && st_q.busy) begin
                st_d.shift = shifted;
                st_d.cnt   = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.busy = 1'b0;
                    st_d.cnt  = '0;
                    st_d.rxb  = shifted;
                    xfer_end  = 1'b1;
                end
            end
        end else begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
            st_d.sck  = 1'b0;
            if (load) st_d.shift = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign sck     = st_q.sck;
    assign tx_bit  = st_q.shift[W-1];
    assign rx_byte = st_q.rxb;

    assert_end_goes_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> !busy);

    assert_sck_low_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_end |=> $stable(rx_byte));

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
    import spi_fault_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stat_rd,
    input  logic   data_acc,
    input  logic   ctrl_wr,
    input  logic   set_done,
    input  logic   set_wcol,
    input  logic   set_modf,
    output flags_t flags
);
    typedef struct packed {
        flags_t fl;
        flags_t arm;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // step one: a status read arms each flag that it saw set
        if (stat_rd) st_d.arm = st_q.arm | st_q.fl;
        // step two: the matching access clears the armed flags
        if (data_acc && st_q.arm.done) begin
            st_d.fl.done  = 1'b0;
            st_d.arm.done = 1'b0;
        end
        if (data_acc && st_q.arm.wcol) begin
            st_d.fl.wcol  = 1'b0;
            st_d.arm.wcol = 1'b0;
        end
        if (ctrl_wr && st_q.arm.modf) begin
            st_d.fl.modf  = 1'b0;
            st_d.arm.modf = 1'b0;
        end
        // new events win over a clear in the same cycle
        if (set_done) st_d.fl.done = 1'b1;
        if (set_wcol) st_d.fl.wcol = 1'b1;
        if (set_modf) st_d.fl.modf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.fl;

    assert_wcol_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flags.wcol && !data_acc |=> flags.wcol);

    assert_done_clear_by_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags.done) |-> $past(data_acc));

    assert_modf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags.modf && !ctrl_wr |=> flags.modf);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_done && set_wcol |=> flags.done && flags.wcol);

endmodule

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl
    import spi_fault_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t      ctrl;
        logic [1:0] ss_sy;
        logic [1:0] sck_sy;
        logic [1:0] mosi_sy;
    } top_st_t;

    top_st_t st_d, st_q;

    logic ctrl_wr, stat_rd, data_wr, data_acc;
    logic ss_s, fault, master_mode, slave_sel;
    logic busy, xfer_end, tick, load, collide, sck_q, tx_bit;
    logic [DATA_W-1:0] rx_byte;
    flags_t flags;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

    always_comb begin
        ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
        stat_rd  = bus_rd && (bus_addr == ADDR_STAT);
        data_wr  = bus_wr && (bus_addr == ADDR_DATA);
        data_acc = (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);

        ss_s        = st_q.ss_sy[1];
        master_mode = st_q.ctrl.en && st_q.ctrl.mstr;
        slave_sel   = st_q.ctrl.en && !st_q.ctrl.mstr && !ss_s;
        fault       = master_mode && !st_q.ctrl.ss_out && !ss_s;
        load        = data_wr && !busy;
        collide     = data_wr && busy;

        st_d         = st_q;
        st_d.ss_sy   = {st_q.ss_sy[0], ss_n_i};
        st_d.sck_sy  = {st_q.sck_sy[0], sck_i};
        st_d.mosi_sy = {st_q.mosi_sy[0], mosi_i};
        if (ctrl_wr) st_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (fault)   st_d.ctrl.mstr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ss_sy <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    spi_clk_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (master_mode && busy),
        .tick  (tick)
    );

    spi_shift_engine #(.W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .master    (master_mode),
        .slave_sel (slave_sel),
        .abort     (fault),
        .tick      (tick),
        .load      (load),
        .load_data (bus_wdata),
        .miso_i    (miso_i),
        .sck_s     (st_q.sck_sy[1]),
        .mosi_s    (st_q.mosi_sy[1]),
        .busy      (busy),
        .xfer_end  (xfer_end),
        .sck       (sck_q),
        .tx_bit    (tx_bit),
        .rx_byte   (rx_byte)
    );

    spi_flag_unit u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_rd  (stat_rd),
        .data_acc (data_acc),
        .ctrl_wr  (ctrl_wr),
        .set_done (xfer_end),
        .set_wcol (collide),
        .set_modf (fault),
        .flags    (flags)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata[CTRL_W-1:0] = st_q.ctrl;
            ADDR_STAT: bus_rdata[$bits(flags_t)-1:0] = flags;
            ADDR_DATA: bus_rdata = rx_byte;
            default:   bus_rdata = '0;
        endcase
    end

    assign sck_o   = sck_q;
    assign sck_oe  = master_mode;
    assign mosi_o  = tx_bit;
    assign mosi_oe = master_mode;
    assign miso_o  = tx_bit;
    assign miso_oe = slave_sel;

    assert_busy_write_collides_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && busy |=> flags.wcol);

    assert_fault_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !st_q.ctrl.mstr && !sck_oe && !mosi_oe && !busy);

    assert_no_fault_with_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.ss_out && !ctrl_wr && !flags.modf |=> !flags.modf);

    assert_drivers_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(miso_oe && mosi_oe));

endmodule

// File: tb/spi_fault_ctrl_bench.sv
module spi_fault_ctrl_bench;
    localparam int DIV = 2;
    localparam int XCYC = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_i = 1'b0;
    logic       sck_o, sck_oe;
    logic       mosi_i = 1'b0;
    logic       mosi_o, mosi_oe;
    logic       miso_i;
    logic       miso_o, miso_oe;
    logic       ss_n_i = 1'b1;

    int n_chk = 0;
    int n_err = 0;

    // partner slave model for master-mode tests
    logic [7:0] bs_sh = 8'h00;
    logic [7:0] bs_rx = 8'h00;
    logic [7:0] bs_val = 8'h00;
    logic       bs_ld = 1'b0;
    logic       bs_cap = 1'b0;

    always #5 clk = ~clk;

    spi_fault_ctrl #(.DATA_W(8), .DIV_HALF(DIV)) u_spi_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i)
    );

    assign miso_i = bs_sh[7];

    always @(posedge sck_o) bs_cap = mosi_o;

    always @(posedge bs_ld or negedge sck_o) begin
        if (bs_ld) begin
            bs_sh = bs_val;
        end else begin
            bs_sh = {bs_sh[6:0], 1'b0};
            bs_rx = {bs_rx[6:0], bs_cap};
        end
    end

    function automatic logic [7:0] stat_word(input bit done, input bit wcol, input bit modf);
        return {5'b0, modf, wcol, done};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load_partner(input logic [7:0] v);
        bs_val = v; bs_ld = 1'b1;
        #1;
        bs_ld = 1'b0;
    endtask

    // full master exchange with cycle-exact completion check (R2)
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sv, input bit pre_done,
                               input string tag);
        logic [7:0] v;
        load_partner(sv);
        bus_write(2'd2, tx);
        repeat (XCYC - 1) @(negedge clk);
        peek(2'd1, v);
        chk({tag, " R2 done not early"}, {7'b0, v[0]}, {7'b0, pre_done});
        @(negedge clk);
        peek(2'd1, v);
        chk({tag, " R2 done on time"}, {7'b0, v[0]}, 8'h01);
        peek(2'd2, v);
        chk({tag, " R2 received byte"}, v, sv);
        chk({tag, " R2 partner got byte"}, bs_rx, tx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v, tx, sv, last_rx, cap;
        int unsigned seed_v;
        bit e_done;
        seed_v = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, v); chk("R1 control", v, 8'h00);
        peek(2'd1, v); chk("R1 status", v, 8'h00);
        peek(2'd2, v); chk("R1 data", v, 8'h00);
        chk("R1 enables", {5'b0, sck_oe, mosi_oe, miso_oe}, 8'h00);

        // R2 directed master exchange
        bus_write(2'd0, 8'h03);
        master_xfer(8'hA5, 8'h3C, 1'b0, "directed");
        e_done = 1'b1;

        // R2/R6 random exchanges and random clear attempts
        for (int i = 0; i < 12; i++) begin
            tx = 8'($urandom);
            sv = 8'($urandom);
            master_xfer(tx, sv, e_done, "random");
            e_done = 1'b1;
            if ($urandom % 2 == 0) begin
                bus_read(2'd1, v);
                bus_read(2'd2, v);
                e_done = 1'b0;
            end else begin
                bus_read(2'd2, v);
            end
            peek(2'd1, v);
            chk("R6 done clear sequence", v, stat_word(e_done, 1'b0, 1'b0));
            last_rx = sv;
        end

        // clear done before collision tests
        bus_read(2'd1, v);
        bus_read(2'd2, v);

        // R3 double-buffered read, R4 collision keeps original data
        load_partner(8'h96);
        bus_write(2'd2, 8'h5A);
        repeat (5) @(negedge clk);
        peek(2'd2, v);
        chk("R3 mid-transfer read", v, last_rx);
        bus_write(2'd2, 8'hFF);
        repeat (XCYC - 6) @(negedge clk);
        peek(2'd1, v); chk("R4 flags after collision", v, stat_word(1'b1, 1'b1, 1'b0));
        peek(2'd2, v); chk("R4 received byte intact", v, 8'h96);
        chk("R4 partner got original", bs_rx, 8'h5A);

        // R5 clear needs status read first
        bus_read(2'd2, v);
        peek(2'd1, v); chk("R5 data access alone", v, stat_word(1'b1, 1'b1, 1'b0));
        bus_read(2'd1, v);
        bus_write(2'd2, 8'h00);
        peek(2'd1, v); chk("R5 clear sequence", v, stat_word(1'b0, 1'b0, 1'b0));
        repeat (XCYC + 2) @(negedge clk);
        bus_read(2'd1, v);
        bus_read(2'd2, v);

        // R11 write on the eighth-shift edge
        load_partner(8'hC3);
        bus_write(2'd2, 8'h81);
        repeat (XCYC - 1) @(negedge clk);
        bus_write(2'd2, 8'h7E);
        peek(2'd1, v); chk("R11 both flags", v, stat_word(1'b1, 1'b1, 1'b0));
        peek(2'd2, v); chk("R11 received byte", v, 8'hC3);
        chk("R11 partner byte", bs_rx, 8'h81);
        bus_read(2'd1, v);
        bus_read(2'd2, v);
        peek(2'd1, v); chk("R11 cleared", v, 8'h00);

        // R7 mode fault when idle
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        peek(2'd1, v); chk("R7 fault flag", v, stat_word(1'b0, 1'b0, 1'b1));
        peek(2'd0, v); chk("R7 master dropped", v, 8'h01);
        chk("R7 lines released", {6'b0, sck_oe, mosi_oe}, 8'h00);
        ss_n_i = 1'b1;
        repeat (3) @(negedge clk);

        // R9 control write without status read keeps flag
        bus_write(2'd0, 8'h03);
        peek(2'd1, v); chk("R9 ctrl write alone", v, stat_word(1'b0, 1'b0, 1'b1));
        bus_read(2'd1, v);
        bus_write(2'd0, 8'h03);
        peek(2'd1, v); chk("R9 clear sequence", v, 8'h00);

        // R7 fault aborts a running transfer
        load_partner(8'h11);
        bus_write(2'd2, 8'h22);
        repeat (5) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 abort releases sck", {7'b0, sck_oe}, 8'h00);
        ss_n_i = 1'b1;
        repeat (XCYC) @(negedge clk);
        peek(2'd1, v); chk("R7 abort no done", v, stat_word(1'b0, 1'b0, 1'b1));
        bus_read(2'd1, v);
        bus_read(2'd2, v);
        peek(2'd1, v); chk("R9 data access keeps fault", v, stat_word(1'b0, 1'b0, 1'b1));
        bus_write(2'd0, 8'h03);
        peek(2'd1, v); chk("R9 armed ctrl write clears", v, 8'h00);
        master_xfer(8'hE7, 8'h18, 1'b0, "R7 recovery");

        // R8 slave-select as output: no fault
        bus_write(2'd0, 8'h07);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        peek(2'd1, v); chk("R8 no fault", {7'b0, v[2]}, 8'h00);
        peek(2'd0, v); chk("R8 master kept", v, 8'h07);
        chk("R8 sck driven", {7'b0, sck_oe}, 8'h01);
        ss_n_i = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(2'd1, v);
        bus_read(2'd2, v);

        // R10 slave mode exchange
        bus_write(2'd0, 8'h01);
        peek(2'd1, v);
        chk("R10 miso idle", {7'b0, miso_oe}, 8'h00);
        bus_write(2'd2, 8'hB4);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 miso driven", {7'b0, miso_oe}, 8'h01);
        tx = 8'h6D;
        cap = 8'h00;
        for (int b = 7; b >= 0; b--) begin
            mosi_i = tx[b];
            repeat (4) @(negedge clk);
            cap = {cap[6:0], miso_o};
            sck_i = 1'b1;
            repeat (4) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
        peek(2'd1, v); chk("R10 slave done", v, stat_word(1'b1, 1'b0, 1'b0));
        peek(2'd2, v); chk("R10 slave received", v, tx);
        chk("R10 master saw", cap, 8'hB4);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 miso released", {7'b0, miso_oe}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule